// File: doc/BRIEF.md
# Processor Halt State Controller

This block sits beside a processor's execution unit and holds the halted condition. A one-cycle halt request from the instruction decoder puts it into the halted state. On entry it issues a halt indication that suits the bus mode. In minimum mode the indication is a single address-latch pulse, with no read, write or other qualifying strobe. In maximum mode the indication is a halt code on the three status lines, from which an external bus controller makes the latch pulse itself. The bus mode is a strap input that is captured while the block reset is held.

While halted, the block grants the local bus hold handshake. A hold never ends the halted state. When the hold is released, the block issues the halt indication again. The halted state ends on a core reset request, on a non-maskable interrupt, or on a maskable interrupt when the interrupt-enable flag is set. The exit cause is reported with a one-cycle valid pulse.

Top module: `hlt_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it was low, the outputs show the running state: `halted_o`=0, `ale_o`=0, `status_o`=3'b111, `hold_ack_o`=0, `wake_valid_o`=0, `wake_cause_o`=2'b00.
- R2: In minimum mode (strap 0), a halt request while running sets `halted_o` and raises `ale_o` for exactly one cycle, in the cycle after the request. `status_o` stays at 3'b111 throughout.
- R3: In maximum mode (strap 1), a halt request while running sets `halted_o` and drives `status_o`=3'b011 for exactly one cycle, in the cycle after the request. The status then returns to 3'b111, and `ale_o` stays 0.
- R4: The mode strap `mode_max_i` is captured only while `rst_n` is low. Changes to it after reset have no effect on the kind of indication issued.
- R5: A hold request seen while halted outside an indication cycle raises `hold_ack_o` in the next cycle, and `halted_o` stays 1 for as long as the hold lasts.
- R6: The cycle after the hold request drops, `hold_ack_o` falls and the mode's halt indication is issued again for one cycle. The block stays halted.
- R7: A wake while halted outside a hold clears `halted_o` and pulses `wake_valid_o` for one cycle in the next cycle. The cause on `wake_cause_o` follows priority: core reset 2'b10, then non-maskable interrupt 2'b01, then enabled maskable interrupt 2'b00.
- R8: A maskable interrupt request while `int_en_i`=0 is ignored, and the block stays halted with no wake pulse.
- R9: Wake inputs while running produce no wake pulse. A halt request while already halted issues no new indication.
- R10: A core reset request during a hold ends the halt: the next cycle shows `halted_o`=0, `hold_ack_o`=0 and a wake pulse with cause 2'b10.
- R11: Interrupt requests (maskable or not) during a hold are ignored. The hold stays granted and the block stays halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset; the mode strap is captured while low |
| mode_max_i | input | 1 | Bus mode strap: 1 maximum, 0 minimum |
| halt_req_i | input | 1 | Halt request from the instruction decoder |
| hold_req_i | input | 1 | Local bus hold request |
| nmi_i | input | 1 | Non-maskable interrupt request |
| intr_i | input | 1 | Maskable interrupt request |
| int_en_i | input | 1 | Interrupt-enable flag |
| core_rst_i | input | 1 | Core reset request, highest-priority wake |
| halted_o | output | 1 | Processor is in the halted state |
| ale_o | output | 1 | Address-latch strobe (minimum mode) |
| status_o | output | 3 | Bus status code: 3'b011 halt, 3'b111 passive |
| hold_ack_o | output | 1 | Local bus hold granted |
| wake_valid_o | output | 1 | One-cycle pulse on exit from halt |
| wake_cause_o | output | 2 | Exit cause: 2'b10 reset, 2'b01 NMI, 2'b00 INTR |

## Verification
The bench applies all three wake sources at once and checks that the reset and non-maskable causes beat the lower ones. A wrong priority encoder would report the wrong cause code. It releases a hold and checks that the halt indication comes again. A design that resumed execution on the hold, or skipped the re-issue, would clear `halted_o` or leave `ale_o` and `status_o` quiet. It also raises an interrupt while interrupts are disabled, raises interrupts during a hold, and toggles the mode strap after reset. A design that wakes on a masked request, or that follows the strap live, shows a stray wake pulse or the wrong kind of indication.

// File: rtl/hlt_pkg.sv
// Package: shared types and encodings for the halt controller.
// Assumes: a three-bit bus status and a two-bit wake-cause code.
package hlt_pkg;
    localparam int STAT_W  = 3;
    localparam int CAUSE_W = 2;

    localparam logic [STAT_W-1:0]  STAT_HALT    = 3'b011;
    localparam logic [STAT_W-1:0]  STAT_PASSIVE = 3'b111;

    localparam logic [CAUSE_W-1:0] CAUSE_INTR = 2'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_NMI  = 2'd1;
    localparam logic [CAUSE_W-1:0] CAUSE_RST  = 2'd2;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_HALTED = 2'd2,
        ST_HOLD   = 2'd3
    } hlt_state_e;
endpackage

// File: rtl/hlt_mode_latch.sv
// Module: captures the bus mode strap while the block reset is held.
// Assumes: the strap is stable during reset; later changes are ignored.
module hlt_mode_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_i,
    output logic mode_o
);
    logic mode_q;

    // Sample the strap only in reset cycles, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= mode_i;
    end

    assign mode_o = mode_q;
endmodule

// File: rtl/hlt_wake_arb.sv
// Module: resolves concurrent wake sources into one fixed-priority cause.
// Assumes: inputs are levels already synchronised to clk.
module hlt_wake_arb
    import hlt_pkg::*;
(
    input  logic               core_rst_i,
    input  logic               nmi_i,
    input  logic               intr_i,
    input  logic               int_en_i,
    output logic               wake_o,
    output logic [CAUSE_W-1:0] cause_o
);
    // Reset beats NMI, which beats an enabled maskable interrupt.
    always_comb begin
        wake_o  = 1'b1;
        cause_o = CAUSE_INTR;
        if (core_rst_i)            cause_o = CAUSE_RST;
        else if (nmi_i)            cause_o = CAUSE_NMI;
        else if (intr_i && int_en_i) cause_o = CAUSE_INTR;
        else                       wake_o  = 1'b0;
    end
endmodule

// File: rtl/hlt_fsm.sv
// Module: halt state sequencer with hold handling and the wake report.
// Assumes: halt_req_i is a decoder pulse; wake sources are levels.
module hlt_fsm
    import hlt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               halt_req_i,
    input  logic               hold_req_i,
    input  logic               core_rst_i,
    input  logic               wake_i,
    input  logic [CAUSE_W-1:0] cause_i,
    output hlt_state_e         state_o,
    output logic               wake_valid_o,
    output logic [CAUSE_W-1:0] wake_cause_o
);
    hlt_state_e         state_q, state_d;
    logic               wv_d, wv_q;
    logic [CAUSE_W-1:0] cause_d, cause_q;

    // Next-state choice and the wake report for the coming cycle.
    always_comb begin
        state_d = state_q;
        wv_d    = 1'b0;
        cause_d = CAUSE_INTR;
        unique case (state_q)
            ST_RUN: begin
                if (halt_req_i) state_d = ST_ISSUE;
            end
            ST_ISSUE: begin
                if (wake_i) begin
                    state_d = ST_RUN;
                    wv_d    = 1'b1;
                    cause_d = cause_i;
                end else begin
                    state_d = ST_HALTED;
                end
            end
            ST_HALTED: begin
                if (wake_i) begin
                    state_d = ST_RUN;
                    wv_d    = 1'b1;
                    cause_d = cause_i;
                end else if (hold_req_i) begin
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (core_rst_i) begin
                    state_d = ST_RUN;
                    wv_d    = 1'b1;
                    cause_d = CAUSE_RST;
                end else if (!hold_req_i) begin
                    state_d = ST_ISSUE;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    // State and wake report registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            wv_q    <= 1'b0;
            cause_q <= CAUSE_INTR;
        end else begin
            state_q <= state_d;
            wv_q    <= wv_d;
            cause_q <= cause_d;
        end
    end

    assign state_o      = state_q;
    assign wake_valid_o = wv_q;
    assign wake_cause_o = cause_q;
endmodule

// File: rtl/hlt_ind_gen.sv
// Module: turns the sequencer state into the mode-specific bus outputs.
// Assumes: the ISSUE state lasts exactly one cycle.
module hlt_ind_gen
    import hlt_pkg::*;
(
    input  hlt_state_e        state_i,
    input  logic              mode_max_i,
    output logic              ale_o,
    output logic [STAT_W-1:0] status_o,
    output logic              halted_o,
    output logic              hold_ack_o
);
    logic issue;

    // Decode the indication cycle and the halted and hold conditions.
    always_comb begin
        issue      = (state_i == ST_ISSUE);
        ale_o      = issue && !mode_max_i;
        status_o   = (issue && mode_max_i) ? STAT_HALT : STAT_PASSIVE;
        halted_o   = (state_i != ST_RUN);
        hold_ack_o = (state_i == ST_HOLD);
    end
endmodule

// File: rtl/hlt_ctrl.sv
// Module: top of the halt controller; wires the strap latch, the wake
// arbiter, the sequencer and the indication decoder together.
// Assumes: synchronous active-low reset; all inputs synchronous to clk.
module hlt_ctrl
    import hlt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_max_i,
    input  logic               halt_req_i,
    input  logic               hold_req_i,
    input  logic               nmi_i,
    input  logic               intr_i,
    input  logic               int_en_i,
    input  logic               core_rst_i,
    output logic               halted_o,
    output logic               ale_o,
    output logic [STAT_W-1:0]  status_o,
    output logic               hold_ack_o,
    output logic               wake_valid_o,
    output logic [CAUSE_W-1:0] wake_cause_o
);
    logic               mode_max;
    logic               wake;
    logic [CAUSE_W-1:0] cause;
    hlt_state_e         state;

    hlt_mode_latch u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (mode_max_i),
        .mode_o (mode_max)
    );

    hlt_wake_arb u_arb (
        .core_rst_i (core_rst_i),
        .nmi_i      (nmi_i),
        .intr_i     (intr_i),
        .int_en_i   (int_en_i),
        .wake_o     (wake),
        .cause_o    (cause)
    );

    hlt_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .halt_req_i   (halt_req_i),
        .hold_req_i   (hold_req_i),
        .core_rst_i   (core_rst_i),
        .wake_i       (wake),
        .cause_i      (cause),
        .state_o      (state),
        .wake_valid_o (wake_valid_o),
        .wake_cause_o (wake_cause_o)
    );

    hlt_ind_gen u_ind (
        .state_i    (state),
        .mode_max_i (mode_max),
        .ale_o      (ale_o),
        .status_o   (status_o),
        .halted_o   (halted_o),
        .hold_ack_o (hold_ack_o)
    );
endmodule

// File: rtl/hlt_ctrl_chk.sv
// Module: property checker for the halt controller, bound to its top.
// Assumes: observes the top-level ports only.
module hlt_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_max_i,
    input logic       halt_req_i,
    input logic       hold_req_i,
    input logic       nmi_i,
    input logic       intr_i,
    input logic       int_en_i,
    input logic       core_rst_i,
    input logic       halted_o,
    input logic       ale_o,
    input logic [2:0] status_o,
    input logic       hold_ack_o,
    input logic       wake_valid_o,
    input logic [1:0] wake_cause_o
);
    // R2: the latch strobe never lasts more than one cycle.
    p_single_ale_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |=> !ale_o);

    // R3: the status code holds only the halt or passive value, and never
    // shows halt together with a latch strobe.
    p_status_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 3'b111) || (status_o == 3'b011 && !ale_o));

    // R5: a granted hold implies the halted state.
    p_hold_keeps_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack_o |-> halted_o);

    // R6: a hold that ends while still halted re-issues the indication.
    p_reissue_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hold_ack_o) && halted_o) |-> (ale_o || status_o == 3'b011));

    // R7: a wake pulse comes with the halt cleared and a legal cause.
    p_wake_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid_o |-> (!halted_o && wake_cause_o != 2'b11));

    // R8: a masked interrupt alone never ends the halt.
    p_intr_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && intr_i && !int_en_i && !nmi_i && !core_rst_i) |=> halted_o);

    // R9: a wake pulse follows a halted cycle.
    p_wake_needs_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid_o |-> $past(halted_o));

    // R11: interrupts during a hold neither drop the grant nor wake.
    p_hold_ignores_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_ack_o && hold_req_i && !core_rst_i) |=> (hold_ack_o && !wake_valid_o));
endmodule

bind hlt_ctrl hlt_ctrl_chk u_chk (.*);

// File: tb/sim_hlt_ctrl.sv
// Bench: scoreboard-driven check of the halt controller.
module sim_hlt_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_max_i = 1'b0;
    logic       halt_req_i = 1'b0;
    logic       hold_req_i = 1'b0;
    logic       nmi_i = 1'b0;
    logic       intr_i = 1'b0;
    logic       int_en_i = 1'b0;
    logic       core_rst_i = 1'b0;
    logic       halted_o, ale_o, hold_ack_o, wake_valid_o;
    logic [2:0] status_o;
    logic [1:0] wake_cause_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [8:0] val;
        string      req;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    hlt_ctrl u0 (.*);

    // Pack expected outputs: {halted, ale, status, hold_ack, wv, cause}.
    function automatic logic [8:0] ex(logic h, logic a, logic [2:0] s,
                                      logic k, logic v, logic [1:0] c);
        return {h, a, s, k, v, c};
    endfunction

    localparam logic [8:0] IDLE = 9'b0_0_111_0_0_00;

    // One cycle: apply inputs, queue what the outputs must be after the edge.
    task automatic cyc(input logic hr, input logic hq, input logic nm,
                       input logic it, input logic ie, input logic cr,
                       input logic [8:0] e, input string req);
        exp_t item;
        halt_req_i = hr; hold_req_i = hq; nmi_i = nm;
        intr_i = it; int_en_i = ie; core_rst_i = cr;
        item.val = e; item.req = req;
        sb_q.push_back(item);
        @(posedge clk);
        #5;
    endtask

    // Monitor: compare outputs shortly after each edge.
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            exp_t it;
            logic [8:0] act;
            it = sb_q.pop_front();
            act = {halted_o, ale_o, status_o, hold_ack_o, wake_valid_o, wake_cause_o};
            checks++;
            if (act !== it.val) begin
                errors++;
                $display("FAIL %s: actual %b expected %b", it.req, act, it.val);
            end
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #2000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        #5;
        // ---- minimum mode ----
        rst_n = 1'b0; mode_max_i = 1'b0;
        cyc(0,0,0,0,0,0, IDLE, "R1");
        cyc(0,0,1,1,1,1, IDLE, "R1");
        rst_n = 1'b1;
        mode_max_i = 1'b1; // R4: ignored after reset
        cyc(0,0,0,0,0,0, IDLE, "R1");
        cyc(1,0,0,0,0,0, ex(1,1,3'b111,0,0,0), "R2 R4");
        cyc(0,0,0,0,0,0, ex(1,0,3'b111,0,0,0), "R2");
        cyc(1,0,0,0,0,0, ex(1,0,3'b111,0,0,0), "R9");
        cyc(0,0,0,1,0,0, ex(1,0,3'b111,0,0,0), "R8");
        cyc(0,0,0,1,0,0, ex(1,0,3'b111,0,0,0), "R8");
        cyc(0,1,0,0,0,0, ex(1,0,3'b111,1,0,0), "R5");
        cyc(0,1,1,1,1,0, ex(1,0,3'b111,1,0,0), "R11");
        cyc(0,1,0,0,0,0, ex(1,0,3'b111,1,0,0), "R5");
        cyc(0,0,0,0,0,0, ex(1,1,3'b111,0,0,0), "R6");
        cyc(0,0,0,0,0,0, ex(1,0,3'b111,0,0,0), "R6");
        cyc(0,0,1,1,1,0, ex(0,0,3'b111,0,1,2'b01), "R7");
        cyc(0,0,0,0,0,0, IDLE, "R7");
        cyc(0,0,1,1,1,1, IDLE, "R9");
        cyc(1,0,0,0,0,0, ex(1,1,3'b111,0,0,0), "R2");
        cyc(0,0,1,1,1,1, ex(0,0,3'b111,0,1,2'b10), "R7");
        cyc(1,0,0,0,0,0, ex(1,1,3'b111,0,0,0), "R2");
        cyc(0,0,0,0,0,0, ex(1,0,3'b111,0,0,0), "R2");
        cyc(0,0,0,1,1,0, ex(0,0,3'b111,0,1,2'b00), "R7");
        cyc(1,0,0,0,0,0, ex(1,1,3'b111,0,0,0), "R2");
        cyc(0,0,0,0,0,0, ex(1,0,3'b111,0,0,0), "R2");
        cyc(0,1,0,0,0,0, ex(1,0,3'b111,1,0,0), "R5");
        cyc(0,1,0,0,0,1, ex(0,0,3'b111,0,1,2'b10), "R10");
        cyc(0,0,0,0,0,0, IDLE, "R10");
        // ---- maximum mode ----
        rst_n = 1'b0; mode_max_i = 1'b1;
        cyc(0,0,0,0,0,0, IDLE, "R1");
        rst_n = 1'b1;
        mode_max_i = 1'b0; // R4: ignored after reset
        cyc(1,0,0,0,0,0, ex(1,0,3'b011,0,0,0), "R3 R4");
        cyc(0,0,0,0,0,0, ex(1,0,3'b111,0,0,0), "R3");
        cyc(0,1,0,0,0,0, ex(1,0,3'b111,1,0,0), "R5");
        cyc(0,0,0,0,0,0, ex(1,0,3'b011,0,0,0), "R6");
        cyc(0,0,0,1,0,0, ex(1,0,3'b111,0,0,0), "R8");
        cyc(0,0,1,0,0,0, ex(0,0,3'b111,0,1,2'b01), "R7");
        cyc(0,0,0,0,0,0, IDLE, "R7");
        done = 1'b1;
        summary();
    end
endmodule